// File: doc/BRIEF.md
# Packed-Byte SIMD Execution Unit

This unit performs SIMD-within-a-register arithmetic for a 32-bit integer pipeline. Every operand comes from the ordinary integer register file and is split into four 8-bit lanes. There is no separate vector register file. An instruction first runs a lane-wise operation on two operands. It can then fold the four lanes into one 32-bit scalar. Either half can be skipped, so one instruction gives a pure lane-wise result, a pure fold, or both in sequence.

A control word supplies a per-lane write mask and a per-lane swizzle for the second operand. The second operand can also be replaced by a power-of-two constant copied into every lane. One flag picks saturating arithmetic over wrapping arithmetic. Another flag picks whether lanes are read as signed or unsigned. The unit accepts one instruction per cycle and returns each result after a fixed two-cycle latency.

Top module: `simd_swar_unit`

## Requirements
- R1: Lane i occupies result bits [8i+7:8i]. The lane operation code selects the function: 0 pass operand A, 1 add, 2 subtract, 3 multiply (low 8 bits), 4 AND, 5 OR, 6 XOR, 7 minimum, 8 maximum. Codes 9 to 15 behave like 0. With saturation off, arithmetic wraps modulo 256.
- R2: With `sat_i` set, add, subtract and multiply clamp each lane. The range is -128..127 when `sgn_i` is 1 and 0..255 when it is 0. Saturation does not change bitwise, pass, minimum or maximum results.
- R3: `sgn_i` selects signed or unsigned comparison for the lane-wise minimum and maximum.
- R4: With `use_imm_i` set, every lane of operand B is replaced by the constant 2^`imm_sel_i`, for example 1, 2 and so on up to 128.
- R5: Lane i of operand B is taken from source lane `ctrl_i[4+2i+1:4+2i]` of `src_b_i`. The value 0xE4 in bits 11:4 gives identity order.
- R6: With the reduction code at 0, a lane whose mask bit `ctrl_i[i]` is 0 returns lane i of `dst_old_i` unchanged.
- R7: Reduction code 1 sums all lanes whose mask bit is set. Each lane is sign-extended or zero-extended according to `sgn_i`, and the sum is returned as a 32-bit signed value. With `sat_i` set, the sum is clamped to the lane range and then extended.
- R8: Reduction codes 2 and 3 return the minimum and maximum of the lanes whose mask bit is set, extended to 32 bits. When no lane is active, the results are as follows:
  - unsigned minimum gives 255
  - unsigned maximum gives 0
  - signed minimum gives 127
  - signed maximum gives -128
- R9: An instruction presented with `issue_i` high is followed exactly two clock cycles later by `valid_o` high with its result. Back-to-back instructions are accepted every cycle, and results come out in issue order. Without an issue, `valid_o` is low two cycles later.
- R10: During reset, `valid_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction present this cycle |
| src_a_i | input | 32 | First operand, four 8-bit lanes |
| src_b_i | input | 32 | Second operand, swizzled before use |
| dst_old_i | input | 32 | Previous destination value, used for masked lanes |
| use_imm_i | input | 1 | Replace operand B with the replicated constant |
| imm_sel_i | input | 3 | Exponent of the power-of-two constant |
| lane_op_i | input | 4 | Lane-wise operation code |
| red_op_i | input | 2 | Reduction code: 0 none, 1 sum, 2 min, 3 max |
| sat_i | input | 1 | Saturating mode |
| sgn_i | input | 1 | Signed lane interpretation |
| ctrl_i | input | 12 | Bits 3:0 lane mask, bits 11:4 swizzle selectors |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Packed lanes or reduced scalar |

## Verification
The first stage holds a merged lane vector together with its mask and fold controls. A fault in that stage shows up at the ports two cycles after the faulty instruction, in one of three ways:
- a wrong byte in a lane
- a masked lane that does not hold the old destination byte
- a scalar that counts a lane it should have skipped

A dropped or duplicated valid bit shows up as a lost or shifted result in the very next output cycle, because every instruction has exactly the same latency. The bench compares every output cycle against a reference model, so an error is reported in the cycle it appears. The identity values of an empty fold and the clamp limits are driven as directed cases, because random control words seldom reach them.

// File: rtl/simd_swar_pkg.sv
package simd_swar_pkg;

  typedef enum logic [3:0] {
    LOP_PASS = 4'd0,
    LOP_ADD  = 4'd1,
    LOP_SUB  = 4'd2,
    LOP_MUL  = 4'd3,
    LOP_AND  = 4'd4,
    LOP_OR   = 4'd5,
    LOP_XOR  = 4'd6,
    LOP_MIN  = 4'd7,
    LOP_MAX  = 4'd8
  } lane_op_e;

  typedef enum logic [1:0] {
    RED_NONE = 2'd0,
    RED_SUM  = 2'd1,
    RED_MIN  = 2'd2,
    RED_MAX  = 2'd3
  } red_op_e;

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_swar_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  lane_op_e     op_i,
  input  logic         sat_i,
  input  logic         sgn_i,
  output logic [W-1:0] y_o
);
  localparam int EW = 2*W + 2;
  localparam logic signed [EW-1:0] S_LO = {{(EW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [EW-1:0] S_HI = {{(EW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0] U_HI = {{(EW-W){1'b0}}, {W{1'b1}}};

  logic signed [EW-1:0] av, bv, full, lo, hi;
  logic                 arith;

  always_comb begin
    av    = sgn_i ? {{(EW-W){a_i[W-1]}}, a_i} : {{(EW-W){1'b0}}, a_i};
    bv    = sgn_i ? {{(EW-W){b_i[W-1]}}, b_i} : {{(EW-W){1'b0}}, b_i};
    lo    = sgn_i ? S_LO : '0;
    hi    = sgn_i ? S_HI : U_HI;
    arith = 1'b0;
    case (op_i)
      LOP_ADD: begin full = av + bv; arith = 1'b1; end
      LOP_SUB: begin full = av - bv; arith = 1'b1; end
      LOP_MUL: begin full = av * bv; arith = 1'b1; end
      LOP_AND: full = {{(EW-W){1'b0}}, a_i & b_i};
      LOP_OR:  full = {{(EW-W){1'b0}}, a_i | b_i};
      LOP_XOR: full = {{(EW-W){1'b0}}, a_i ^ b_i};
      LOP_MIN: full = (av < bv) ? av : bv;
      LOP_MAX: full = (av > bv) ? av : bv;
      default: full = av;
    endcase
    y_o = full[W-1:0];
    if (sat_i && arith) begin
      if (full < lo)      y_o = lo[W-1:0];
      else if (full > hi) y_o = hi[W-1:0];
    end
  end
endmodule

// File: rtl/simd_lane_reduce.sv
module simd_lane_reduce
  import simd_swar_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 8,
  parameter int OW    = 32
) (
  input  logic [LANES*W-1:0] vec_i,
  input  logic [LANES-1:0]   act_i,
  input  red_op_e            op_i,
  input  logic               sgn_i,
  input  logic               sat_i,
  output logic [OW-1:0]      y_o
);
  localparam logic signed [OW-1:0] S_LO = {{(OW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [OW-1:0] S_HI = {{(OW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [OW-1:0] U_HI = {{(OW-W){1'b0}}, {W{1'b1}}};

  logic signed [OW-1:0] v, sum, mn, mx, lo, hi;

  always_comb begin
    lo  = sgn_i ? S_LO : '0;
    hi  = sgn_i ? S_HI : U_HI;
    v   = '0;
    sum = '0;
    mn  = hi;
    mx  = lo;
    for (int i = 0; i < LANES; i++) begin
      v = sgn_i ? {{(OW-W){vec_i[i*W+W-1]}}, vec_i[i*W +: W]}
                : {{(OW-W){1'b0}}, vec_i[i*W +: W]};
      if (act_i[i]) begin
        sum = sum + v;
        if (v < mn) mn = v;
        if (v > mx) mx = v;
      end
    end
    if (sat_i) begin
      if (sum < lo)      sum = lo;
      else if (sum > hi) sum = hi;
    end
    case (op_i)
      RED_SUM: y_o = sum;
      RED_MIN: y_o = mn;
      RED_MAX: y_o = mx;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_swar_unit.sv
module simd_swar_unit
  import simd_swar_pkg::*;
#(
  parameter  int LANES  = 4,
  parameter  int LANE_W = 8,
  localparam int XLEN   = LANES * LANE_W,
  localparam int SEL_W  = $clog2(LANES),
  localparam int CTRL_W = LANES + LANES * SEL_W,
  localparam int IMM_W  = $clog2(LANE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [XLEN-1:0]   src_a_i,
  input  logic [XLEN-1:0]   src_b_i,
  input  logic [XLEN-1:0]   dst_old_i,
  input  logic              use_imm_i,
  input  logic [IMM_W-1:0]  imm_sel_i,
  input  logic [3:0]        lane_op_i,
  input  logic [1:0]        red_op_i,
  input  logic              sat_i,
  input  logic              sgn_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              valid_o,
  output logic [XLEN-1:0]   result_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // stage 1: operand B selection, lane ALUs, mask merge
  logic [LANE_W-1:0] imm_val;
  logic [XLEN-1:0]   merged;
  assign imm_val = LANE_W'(1) << imm_sel_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SEL_W-1:0]  sel;
    logic [LANE_W-1:0] b_lane, y_lane;
    assign sel    = ctrl_i[LANES + g*SEL_W +: SEL_W];
    assign b_lane = use_imm_i ? imm_val : src_b_i[sel*LANE_W +: LANE_W];
    simd_lane_alu #(.W(LANE_W)) u_alu (
      .a_i   (src_a_i[g*LANE_W +: LANE_W]),
      .b_i   (b_lane),
      .op_i  (lane_op_e'(lane_op_i)),
      .sat_i (sat_i),
      .sgn_i (sgn_i),
      .y_o   (y_lane)
    );
    assign merged[g*LANE_W +: LANE_W] = ctrl_i[g] ? y_lane
                                                  : dst_old_i[g*LANE_W +: LANE_W];
  end

  logic [XLEN-1:0]  s1_vec_q;
  logic [LANES-1:0] s1_act_q;
  red_op_e          s1_red_q;
  logic             s1_sgn_q, s1_sat_q, s1_vld_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s1_vec_q <= '0;
      s1_act_q <= '0;
      s1_red_q <= RED_NONE;
      s1_sgn_q <= 1'b0;
      s1_sat_q <= 1'b0;
      s1_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= issue_i;
      if (issue_i) begin
        s1_vec_q <= merged;
        s1_act_q <= ctrl_i[LANES-1:0];
        s1_red_q <= red_op_e'(red_op_i);
        s1_sgn_q <= sgn_i;
        s1_sat_q <= sat_i;
      end
    end
  end

  // stage 2: optional fold to a scalar
  logic [XLEN-1:0] red_y, out_d;
  simd_lane_reduce #(.LANES(LANES), .W(LANE_W), .OW(XLEN)) u_red (
    .vec_i (s1_vec_q),
    .act_i (s1_act_q),
    .op_i  (s1_red_q),
    .sgn_i (s1_sgn_q),
    .sat_i (s1_sat_q),
    .y_o   (red_y)
  );

  always_comb begin
    out_d = (s1_red_q == RED_NONE) ? s1_vec_q : red_y;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s1_vld_q;
      if (s1_vld_q) result_o <= out_d;
    end
  end
endmodule

// File: rtl/simd_swar_chk.sv
module simd_swar_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int XLEN   = 32,
  parameter int CTRL_W = 12
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              issue_i,
  input logic [XLEN-1:0]   src_a_i,
  input logic [XLEN-1:0]   dst_old_i,
  input logic [3:0]        lane_op_i,
  input logic [1:0]        red_op_i,
  input logic              sat_i,
  input logic              sgn_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              valid_o,
  input logic [XLEN-1:0]   result_o
);
  // R9
  issue_lat_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    issue_i |-> ##2 valid_o);

  // R9
  idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !issue_i |-> ##2 !valid_o);

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (issue_i && red_op_i == 2'd0 && !ctrl_i[g]) |-> ##2
      (result_o[g*LANE_W +: LANE_W] == $past(dst_old_i[g*LANE_W +: LANE_W], 2)));
  end

  // R1
  and_bound_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (issue_i && lane_op_i == 4'd4 && red_op_i == 2'd0 && (&ctrl_i[LANES-1:0])) |-> ##2
    ((result_o & ~$past(src_a_i, 2)) == '0));

  // R2
  usat_add_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (issue_i && lane_op_i == 4'd1 && sat_i && !sgn_i && red_op_i == 2'd0 && ctrl_i[0]) |-> ##2
    (result_o[LANE_W-1:0] >= $past(src_a_i[LANE_W-1:0], 2)));

  // R8
  empty_umin_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (issue_i && red_op_i == 2'd2 && !sgn_i && ctrl_i[LANES-1:0] == '0) |-> ##2
    (result_o == {{(XLEN-LANE_W){1'b0}}, {LANE_W{1'b1}}}));
endmodule

bind simd_swar_unit simd_swar_chk #(
  .LANES(LANES), .LANE_W(LANE_W), .XLEN(XLEN), .CTRL_W(CTRL_W)
) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .issue_i   (issue_i),
  .src_a_i   (src_a_i),
  .dst_old_i (dst_old_i),
  .lane_op_i (lane_op_i),
  .red_op_i  (red_op_i),
  .sat_i     (sat_i),
  .sgn_i     (sgn_i),
  .ctrl_i    (ctrl_i),
  .valid_o   (valid_o),
  .result_o  (result_o)
);

// File: tb/sim_simd_swar_unit.sv
module sim_simd_swar_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i, use_imm_i, sat_i, sgn_i;
  logic [31:0] src_a_i, src_b_i, dst_old_i;
  logic [2:0]  imm_sel_i;
  logic [3:0]  lane_op_i;
  logic [1:0]  red_op_i;
  logic [11:0] ctrl_i;
  logic        valid_o;
  logic [31:0] result_o;

  always #5 clk = ~clk;

  simd_swar_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .src_a_i(src_a_i),
    .src_b_i(src_b_i), .dst_old_i(dst_old_i), .use_imm_i(use_imm_i),
    .imm_sel_i(imm_sel_i), .lane_op_i(lane_op_i), .red_op_i(red_op_i),
    .sat_i(sat_i), .sgn_i(sgn_i), .ctrl_i(ctrl_i), .valid_o(valid_o),
    .result_o(result_o)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit          pv[2];
  logic [31:0] pr[2];
  string       pt[2];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int interp(logic [7:0] x, bit sgn);
    return sgn ? int'($signed(x)) : int'(x);
  endfunction

  function automatic logic [7:0] lane_ref(logic [7:0] ra, logic [7:0] rb,
                                          int op, bit sat, bit sgn);
    int va = interp(ra, sgn);
    int vb = interp(rb, sgn);
    int r;
    int lo = sgn ? -128 : 0;
    int hi = sgn ? 127 : 255;
    case (op)
      1: r = va + vb;
      2: r = va - vb;
      3: r = va * vb;
      4: r = int'(ra & rb);
      5: r = int'(ra | rb);
      6: r = int'(ra ^ rb);
      7: r = (va < vb) ? va : vb;
      8: r = (va > vb) ? va : vb;
      default: r = va;
    endcase
    if (sat && op >= 1 && op <= 3) begin
      if (r < lo) r = lo;
      if (r > hi) r = hi;
    end
    return r[7:0];
  endfunction

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
      logic [31:0] old, bit ui, int imm, int lop, int rop, bit sat, bit sgn,
      logic [11:0] ctrl);
    logic [31:0] v;
    int acc;
    for (int i = 0; i < 4; i++) begin
      int sb = int'(ctrl[4+2*i +: 2]);
      logic [7:0] rb = ui ? (8'd1 << imm) : b[8*sb +: 8];
      v[8*i +: 8] = ctrl[i] ? lane_ref(a[8*i +: 8], rb, lop, sat, sgn) : old[8*i +: 8];
    end
    if (rop == 0) return v;
    if (rop == 1) acc = 0;
    else if (rop == 2) acc = sgn ? 127 : 255;
    else acc = sgn ? -128 : 0;
    for (int i = 0; i < 4; i++) begin
      if (ctrl[i]) begin
        int x = interp(v[8*i +: 8], sgn);
        if (rop == 1) acc += x;
        else if (rop == 2 && x < acc) acc = x;
        else if (rop == 3 && x > acc) acc = x;
      end
    end
    if (rop == 1 && sat) begin
      if (acc < (sgn ? -128 : 0)) acc = sgn ? -128 : 0;
      if (acc > (sgn ? 127 : 255)) acc = sgn ? 127 : 255;
    end
    return 32'(acc);
  endfunction

  task automatic step(bit v, logic [31:0] a, logic [31:0] b, logic [31:0] old,
                      bit ui, int imm, int lop, int rop, bit sat, bit sgn,
                      logic [11:0] ctrl, string tag);
    @(negedge clk);
    check("R9 valid", 32'(valid_o), 32'(pv[1]));
    if (pv[1]) check(pt[1], result_o, pr[1]);
    pv[1] = pv[0]; pr[1] = pr[0]; pt[1] = pt[0];
    pv[0] = v;
    pr[0] = model(a, b, old, ui, imm, lop, rop, sat, sgn, ctrl);
    pt[0] = tag;
    issue_i   = v;
    src_a_i   = a;
    src_b_i   = b;
    dst_old_i = old;
    use_imm_i = ui;
    imm_sel_i = 3'(imm);
    lane_op_i = 4'(lop);
    red_op_i  = 2'(rop);
    sat_i     = sat;
    sgn_i     = sgn;
    ctrl_i    = ctrl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    pv[0] = 0; pv[1] = 0;
    issue_i = 0; src_a_i = '0; src_b_i = '0; dst_old_i = '0; use_imm_i = 0;
    imm_sel_i = '0; lane_op_i = '0; red_op_i = '0; sat_i = 0; sgn_i = 0;
    ctrl_i = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", 32'(valid_o), 32'd0);
    check("R10 reset result", result_o, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // directed lane-wise cases (identity swizzle 0xE4, all lanes on)
    step(1, 32'h7f7f7f7f, 32'h01010101, 0, 0, 0, 1, 0, 0, 1, 12'hE4F, "R1 add wrap");
    step(1, 32'h7f7f7f7f, 32'h01010101, 0, 0, 0, 1, 0, 1, 1, 12'hE4F, "R2 signed add sat");
    step(1, 32'hf0f0f0f0, 32'h20202020, 0, 0, 0, 1, 0, 1, 0, 12'hE4F, "R2 unsigned add sat");
    step(1, 32'h80808080, 32'h01010101, 0, 0, 0, 2, 0, 1, 1, 12'hE4F, "R2 signed sub sat");
    step(1, 32'h10203040, 32'h50607080, 0, 0, 0, 2, 0, 1, 0, 12'hE4F, "R2 unsigned sub sat");
    step(1, 32'h10101010, 32'h10101010, 0, 0, 0, 3, 0, 1, 1, 12'hE4F, "R2 mul sat");
    step(1, 32'h10101010, 32'h10101010, 0, 0, 0, 3, 0, 0, 1, 12'hE4F, "R1 mul wrap");
    step(1, 32'hf0f0f0f0, 32'h3c3c3c3c, 0, 0, 0, 6, 0, 1, 1, 12'hE4F, "R2 xor no sat effect");
    step(1, 32'h80018001, 32'h01800180, 0, 0, 0, 7, 0, 0, 1, 12'hE4F, "R3 signed min");
    step(1, 32'h80018001, 32'h01800180, 0, 0, 0, 7, 0, 0, 0, 12'hE4F, "R3 unsigned min");
    step(1, 32'h80018001, 32'h01800180, 0, 0, 0, 8, 0, 1, 1, 12'hE4F, "R3 signed max");
    step(1, 32'h01020304, 32'hdeadbeef, 0, 1, 7, 1, 0, 0, 0, 12'hE4F, "R4 imm 128");
    step(1, 32'h01020304, 32'hdeadbeef, 0, 1, 0, 2, 0, 0, 0, 12'hE4F, "R4 imm 1");
    step(1, 32'h00000000, 32'h44332211, 0, 0, 0, 5, 0, 0, 0, 12'h1BF, "R5 swizzle reverse");
    step(1, 32'h00000000, 32'h44332211, 0, 0, 0, 5, 0, 0, 0, 12'h00F, "R5 swizzle broadcast");
    step(1, 32'h11111111, 32'h22222222, 32'haabbccdd, 0, 0, 1, 0, 0, 0, 12'hE45, "R6 mask merge");
    step(1, 32'h11111111, 32'h22222222, 32'haabbccdd, 0, 0, 1, 0, 0, 0, 12'hE40, "R6 all masked");
    // directed reductions (lane op 0 passes A)
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 1, 0, 1, 12'hE4F, "R7 signed sum");
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 1, 0, 0, 12'hE4F, "R7 unsigned sum");
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 1, 1, 0, 12'hE4F, "R7 unsigned sum sat");
    step(1, 32'h80808080, 0, 0, 0, 0, 0, 1, 1, 1, 12'hE4F, "R7 signed sum sat");
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 1, 0, 1, 12'hE4A, "R7 masked sum");
    step(1, 32'h11223344, 32'h01010101, 0, 0, 0, 1, 1, 0, 0, 12'hE4F, "R7 add then sum");
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 2, 0, 1, 12'hE4F, "R8 signed min");
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 3, 0, 0, 12'hE4E, "R8 unsigned max masked");
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 2, 0, 0, 12'hE40, "R8 empty unsigned min");
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 3, 0, 1, 12'hE40, "R8 empty signed max");
    step(1, 32'h01ff7f80, 0, 0, 0, 0, 0, 2, 0, 1, 12'hE40, "R8 empty signed min");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 12'h0, "R9 bubble");
    step(1, 32'h05050505, 32'h03030303, 0, 0, 0, 9, 0, 0, 0, 12'hE4F, "R1 undefined op passes A");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int rop = int'($urandom_range(0, 3));
      step(($urandom_range(0, 7) != 0), $urandom, $urandom, $urandom,
           $urandom_range(0, 1), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 15)), rop, $urandom_range(0, 1),
           $urandom_range(0, 1), 12'($urandom),
           rop == 0 ? "R1 random lane" : (rop == 1 ? "R7 random sum" : "R8 random minmax"));
    end
    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 12'h0, "R9 drain");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule